// File: doc/BRIEF.md
# Multi-Mode Configurable I/O Port

This block is an eight-pin general-purpose port that a microcontroller controls through a four-register window. Each pin works in one of three modes. In processor I/O mode the pin is driven from a data-out register, or it is sampled back into a data-in register. In logic I/O mode the pin value and its enable come from programmable-logic signals, and the pin level is passed back to the logic. In address-out mode the pin drives a bit of the latched address. The logic array, the address latch and the boot logic are outside the block. They reach it as plain inputs: a per-pin logic select, a per-pin product-term output enable, an output-macrocell value and a latched address byte.

Each pin has its own output value, output enable and input level instead of a bidirectional pad. A pin's mode is named by a per-pin enumerated state, decided each cycle from its logic-select input, its control bit, its direction bit and its product-term enable. `PIN_LOGIC` applies when the logic select is high. `PIN_ADDR` applies when the control bit is 1 and the direction bit or the enable is 1. `PIN_ADDR_IDLE` applies when the control bit is 1 and both the direction bit and the enable are 0. `PIN_CPU` applies in every other case. No transition is stored: a pin moves between any two states in the same cycle that its inputs change. A build parameter removes the control register, and every pin that is not logic-selected then stays in `PIN_CPU`.

Top module: `ioport_multimode`

## Requirements
- R1: After reset the data-out, direction and control registers read 0. With the logic select and the product-term enables low, every `pad_oe` bit is 0.
- R2: A write with `wr_en` high stores `wr_data` at the edge. Offset 1 is data-out, offset 2 is direction and offset 3 is control. The new value reads back on `rd_data` from the next cycle, and a register is unchanged in any cycle with no write to its offset.
- R3: Offset 0 is read-only and returns `pad_in` as sampled at the previous clock edge. Writes to offset 0 change no register.
- R4: When a pin's logic select is 0 and its control bit is 0 (`PIN_CPU`), its enable is its direction bit OR its product-term enable. While enabled, the pin drives its data-out bit.
- R5: When a pin's logic select is 0, its control bit is 1, and its direction bit or product-term enable is 1 (`PIN_ADDR`), the pin is enabled. Bit i of `addr_lat` drives pin i, so address bits 7 down to 0 appear in bit order.
- R6: When a pin's logic select is 0, its control bit is 1, and its direction bit and product-term enable are both 0 (`PIN_ADDR_IDLE`), the pin is not enabled.
- R7: When a pin's logic select is 1 (`PIN_LOGIC`), the pin is enabled only when both its product-term enable and its direction bit are 1. While enabled, it drives its `mcell_out` bit.
- R8: `imc_out` bit i equals `pad_in` bit i while logic select bit i is 1, whatever the direction bit, and is 0 otherwise.
- R9: With `HAS_CTRL` = 0, the control register is absent. Offset 3 reads 0, writes to it are ignored, and pins that are not logic-selected behave as `PIN_CPU`.
- R10: A pin whose `pad_oe` bit is 0 has its `pad_out` bit at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write offset |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read offset |
| rd_data | output | 8 | Read data for `rd_addr` |
| logic_sel | input | 8 | Per-pin logic I/O select |
| pt_oe | input | 8 | Per-pin product-term output enable |
| mcell_out | input | 8 | Output-macrocell values |
| addr_lat | input | 8 | Latched address byte |
| pad_in | input | 8 | Pin levels |
| pad_out | output | 8 | Pin drive values |
| pad_oe | output | 8 | Pin output enables |
| imc_out | output | 8 | Pin levels forwarded to input macrocells |

## Verification
The assertions check on every cycle that a disabled pin drives 0 and that a logic-mode pin is enabled only when its direction bit and product-term enable are both 1. They also check that an address-mode pin drives its address bit, that the input-macrocell path is silent for pins that are not logic-selected, that data-out holds between writes, and that the control register stays 0 when it is absent. Only the bench scenarios show the reset values, the register readback, that writes to offset 0 are ignored, the one-cycle delay of the data-in path, and that the full mode decode agrees with an independent model over random mixes of register and input values for both build variants.

// File: rtl/port_cfg_pkg.sv
`timescale 1ns/1ps
package port_cfg_pkg;
    localparam int OFS_W = 2;

    localparam logic [OFS_W-1:0] OFS_DIN  = 2'd0;
    localparam logic [OFS_W-1:0] OFS_DOUT = 2'd1;
    localparam logic [OFS_W-1:0] OFS_DIR  = 2'd2;
    localparam logic [OFS_W-1:0] OFS_CTRL = 2'd3;

    typedef enum logic [1:0] {
        PIN_CPU       = 2'd0,
        PIN_ADDR      = 2'd1,
        PIN_ADDR_IDLE = 2'd2,
        PIN_LOGIC     = 2'd3
    } pin_mode_e;
endpackage

// File: rtl/port_regs.sv
`timescale 1ns/1ps
module port_regs
    import port_cfg_pkg::*;
#(
    parameter int W        = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [OFS_W-1:0] rd_addr,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     rd_data,
    output logic [W-1:0]     dout_q,
    output logic [W-1:0]     dir_q,
    output logic [W-1:0]     ctrl_q
);
    logic [W-1:0] din_q;

    // Data-in sample register; it is read-only, so software writes never reach it.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) din_q <= '0;
        else        din_q <= pad_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dout_q <= '0;
            dir_q  <= '0;
        end else if (wr_en) begin
            if (wr_addr == OFS_DOUT) dout_q <= wr_data;
            if (wr_addr == OFS_DIR)  dir_q  <= wr_data;
        end
    end

    generate
        if (HAS_CTRL) begin : g_ctrl
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)                             ctrl_q <= '0;
                else if (wr_en && wr_addr == OFS_CTRL)  ctrl_q <= wr_data;
            end
        end else begin : g_no_ctrl
            assign ctrl_q = '0;
            // R9: an absent control register never leaves processor I/O
            assert_ctrl_absent_R9: assert property (@(posedge clk) disable iff (!rst_n)
                ctrl_q == '0);
        end
    endgenerate

    always_comb begin
        unique case (rd_addr)
            OFS_DIN:  rd_data = din_q;
            OFS_DOUT: rd_data = dout_q;
            OFS_DIR:  rd_data = dir_q;
            OFS_CTRL: rd_data = ctrl_q;
            default:  rd_data = '0;
        endcase
    end

    // R2: data-out only moves on a write to its own offset
    assert_dout_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == OFS_DOUT) |=> $stable(dout_q));
    assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_addr == OFS_DIR) |=> $stable(dir_q));
endmodule

// File: rtl/port_pin_mux.sv
`timescale 1ns/1ps
module port_pin_mux
    import port_cfg_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] dout_q,
    input  logic [W-1:0] dir_q,
    input  logic [W-1:0] ctrl_q,
    input  logic [W-1:0] logic_sel,
    input  logic [W-1:0] pt_oe,
    input  logic [W-1:0] mcell_out,
    input  logic [W-1:0] addr_lat,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] pad_out,
    output logic [W-1:0] pad_oe,
    output logic [W-1:0] imc_out
);
    generate
        for (genvar i = 0; i < W; i++) begin : g_pin
            pin_mode_e mode;

            // Mode decode: logic select wins, then the control bit picks address-out.
            always_comb begin
                if (logic_sel[i])      mode = PIN_LOGIC;
                else if (ctrl_q[i])    mode = (dir_q[i] | pt_oe[i]) ? PIN_ADDR : PIN_ADDR_IDLE;
                else                   mode = PIN_CPU;
            end

            // Drive per mode; a disabled pin always presents 0.
            always_comb begin
                unique case (mode)
                    PIN_CPU: begin
                        pad_oe[i]  = dir_q[i] | pt_oe[i];
                        pad_out[i] = pad_oe[i] & dout_q[i];
                    end
                    PIN_ADDR: begin
                        pad_oe[i]  = 1'b1;
                        pad_out[i] = addr_lat[i];
                    end
                    PIN_ADDR_IDLE: begin
                        pad_oe[i]  = 1'b0;
                        pad_out[i] = 1'b0;
                    end
                    PIN_LOGIC: begin
                        pad_oe[i]  = pt_oe[i] & dir_q[i];
                        pad_out[i] = pad_oe[i] & mcell_out[i];
                    end
                    default: begin
                        pad_oe[i]  = 1'b0;
                        pad_out[i] = 1'b0;
                    end
                endcase
            end

            assign imc_out[i] = logic_sel[i] & pad_in[i];

            // R10: a released pin carries no value
            assert_quiet_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
                !pad_oe[i] |-> !pad_out[i]);
            // R7: logic drive needs both the term enable and the direction bit
            assert_logic_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (logic_sel[i] && pad_oe[i]) |-> (pt_oe[i] && dir_q[i]));
            // R5: address-out pins carry their own address bit
            assert_addr_drive_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (!logic_sel[i] && ctrl_q[i] && (dir_q[i] || pt_oe[i]))
                    |-> (pad_oe[i] && pad_out[i] == addr_lat[i]));
            // R8: input macrocells only see logic-selected pins
            assert_imc_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
                !logic_sel[i] |-> !imc_out[i]);
        end
    endgenerate
endmodule

// File: rtl/ioport_multimode.sv
`timescale 1ns/1ps
module ioport_multimode
    import port_cfg_pkg::*;
#(
    parameter int W        = 8,
    parameter bit HAS_CTRL = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] wr_addr,
    input  logic [W-1:0]     wr_data,
    input  logic [OFS_W-1:0] rd_addr,
    output logic [W-1:0]     rd_data,
    input  logic [W-1:0]     logic_sel,
    input  logic [W-1:0]     pt_oe,
    input  logic [W-1:0]     mcell_out,
    input  logic [W-1:0]     addr_lat,
    input  logic [W-1:0]     pad_in,
    output logic [W-1:0]     pad_out,
    output logic [W-1:0]     pad_oe,
    output logic [W-1:0]     imc_out
);
    logic [W-1:0] dout_q;
    logic [W-1:0] dir_q;
    logic [W-1:0] ctrl_q;

    port_regs #(.W(W), .HAS_CTRL(HAS_CTRL)) regs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .pad_in  (pad_in),
        .rd_data (rd_data),
        .dout_q  (dout_q),
        .dir_q   (dir_q),
        .ctrl_q  (ctrl_q)
    );

    port_pin_mux #(.W(W)) mux_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .dout_q    (dout_q),
        .dir_q     (dir_q),
        .ctrl_q    (ctrl_q),
        .logic_sel (logic_sel),
        .pt_oe     (pt_oe),
        .mcell_out (mcell_out),
        .addr_lat  (addr_lat),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .imc_out   (imc_out)
    );
endmodule

// File: tb/ioport_multimode_tb_top.sv
`timescale 1ns/1ps
module ioport_multimode_tb_top;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [1:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [1:0]   rd_addr = '0;
    logic [W-1:0] logic_sel = '0, pt_oe = '0, mcell_out = '0, addr_lat = '0, pad_in = '0;
    logic [W-1:0] rd_data, pad_out, pad_oe, imc_out;
    logic [W-1:0] nc_rd_data, nc_pad_out, nc_pad_oe, nc_imc_out;

    int checks = 0;
    int fails  = 0;
    logic [W-1:0] m_dout = '0, m_dir = '0, m_ctrl = '0;

    always #2 clk = ~clk;

    ioport_multimode #(.W(W), .HAS_CTRL(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .logic_sel(logic_sel), .pt_oe(pt_oe),
        .mcell_out(mcell_out), .addr_lat(addr_lat), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .imc_out(imc_out));

    ioport_multimode #(.W(W), .HAS_CTRL(1'b0)) dut_nc_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(nc_rd_data), .logic_sel(logic_sel), .pt_oe(pt_oe),
        .mcell_out(mcell_out), .addr_lat(addr_lat), .pad_in(pad_in),
        .pad_out(nc_pad_out), .pad_oe(nc_pad_oe), .imc_out(nc_imc_out));

    task automatic check(input string req, input string what, input logic [W-1:0] act,
                         input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Model of one pin: returns {oe, out}
    function automatic logic [1:0] exp_pin(input logic d, input logic dr, input logic c,
                                           input logic ls, input logic pt, input logic mc,
                                           input logic al);
        logic oe;
        if (ls) begin
            oe = pt & dr;
            return {oe, oe & mc};
        end
        oe = dr | pt;
        if (c) return {oe, oe & al};
        return {oe, oe & d};
    endfunction

    function automatic string req_of(input logic c, input logic dr, input logic ls,
                                     input logic pt);
        if (ls) return "R7";
        if (c && (dr || pt)) return "R5";
        if (c) return "R6";
        return "R4";
    endfunction

    task automatic do_write(input logic [1:0] a, input logic [W-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (a == 2'd1) m_dout = d;
        if (a == 2'd2) m_dir  = d;
        if (a == 2'd3) m_ctrl = d;
    endtask

    task automatic check_pins();
        logic [1:0] e;
        logic [W-1:0] eo, eu, no, nu;
        #1;
        for (int i = 0; i < W; i++) begin
            e = exp_pin(m_dout[i], m_dir[i], m_ctrl[i], logic_sel[i], pt_oe[i],
                        mcell_out[i], addr_lat[i]);
            eo[i] = e[1]; eu[i] = e[0];
            checks++;
            if (pad_oe[i] !== e[1] || pad_out[i] !== e[0]) begin
                fails++;
                $display("FAIL %s pin %0d: actual oe/out %b%b expected %b%b",
                         req_of(m_ctrl[i], m_dir[i], logic_sel[i], pt_oe[i]), i,
                         pad_oe[i], pad_out[i], e[1], e[0]);
            end
            e = exp_pin(m_dout[i], m_dir[i], 1'b0, logic_sel[i], pt_oe[i],
                        mcell_out[i], addr_lat[i]);
            no[i] = e[1]; nu[i] = e[0];
        end
        check("R10", "released pins quiet", pad_out & ~pad_oe, '0);
        check("R8", "imc forward", imc_out, pad_in & logic_sel);
        check("R9", "no-ctrl oe", nc_pad_oe, no);
        check("R9", "no-ctrl out", nc_pad_out, nu);
        check("R8", "no-ctrl imc", nc_imc_out, pad_in & logic_sel);
        if (eo === eu) begin end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin : main
        logic [W-1:0] s;
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        rd_addr = 2'd1; #1 check("R1", "dout reset", rd_data, '0);
        rd_addr = 2'd2; #1 check("R1", "dir reset", rd_data, '0);
        rd_addr = 2'd3; #1 check("R1", "ctrl reset", rd_data, '0);
        check("R1", "pad_oe reset", pad_oe, '0);

        // R2 write/readback
        do_write(2'd1, 8'hA5); do_write(2'd2, 8'h3C); do_write(2'd3, 8'hF0);
        rd_addr = 2'd1; #1 check("R2", "dout readback", rd_data, 8'hA5);
        rd_addr = 2'd2; #1 check("R2", "dir readback", rd_data, 8'h3C);
        rd_addr = 2'd3; #1 check("R2", "ctrl readback", rd_data, 8'hF0);
        // R9 control absent
        check("R9", "no-ctrl reads 0", nc_rd_data, '0);

        // R3 offset 0 write ignored, data-in path delayed one edge
        pad_in = 8'h96;
        do_write(2'd0, 8'h11);
        rd_addr = 2'd1; #1 check("R3", "dout after din write", rd_data, 8'hA5);
        rd_addr = 2'd2; #1 check("R3", "dir after din write", rd_data, 8'h3C);
        rd_addr = 2'd3; #1 check("R3", "ctrl after din write", rd_data, 8'hF0);
        rd_addr = 2'd0; #1 check("R3", "data-in value", rd_data, 8'h96);
        @(negedge clk); pad_in = 8'h69; #1 check("R3", "data-in lags", rd_data, 8'h96);
        @(negedge clk); #1 check("R3", "data-in updated", rd_data, 8'h69);

        // Directed: address mode with every pin, A7..A0 in bit order (R5)
        do_write(2'd3, 8'hFF); do_write(2'd2, 8'hFF);
        addr_lat = 8'h81; logic_sel = '0; pt_oe = '0;
        #1 check("R5", "address byte order", pad_out, 8'h81);
        check("R5", "address all enabled", pad_oe, 8'hFF);
        // Directed: control set, direction clear, no term: idle (R6)
        do_write(2'd2, 8'h00);
        #1 check("R6", "addr idle released", pad_oe, 8'h00);
        // Directed: term enable forces address-out (R5)
        pt_oe = 8'h0F;
        #1 check("R5", "term enters address-out", pad_oe, 8'h0F);
        // Directed: logic mode, direction 0 blocks output but imc forwards (R7, R8)
        logic_sel = 8'hFF; pt_oe = 8'hFF; mcell_out = 8'h5A; pad_in = 8'hC3;
        #1 check("R7", "logic dir0 disabled", pad_oe, 8'h00);
        check("R8", "imc with dir0", imc_out, 8'hC3);
        do_write(2'd2, 8'hFF);
        #1 check("R7", "logic drives mcell", pad_out, 8'h5A);
        // Directed: processor output (R4)
        logic_sel = '0; pt_oe = '0;
        do_write(2'd3, 8'h00); do_write(2'd1, 8'h3E);
        #1 check("R4", "cpu output", pad_out, 8'h3E);

        // Random mix
        for (int n = 0; n < 150; n++) begin
            s = 8'($urandom);
            do_write(2'd1, 8'($urandom));
            do_write(2'd2, 8'($urandom));
            do_write(2'd3, s);
            logic_sel = 8'($urandom) & 8'($urandom);
            pt_oe     = 8'($urandom) & 8'($urandom);
            mcell_out = 8'($urandom);
            addr_lat  = 8'($urandom);
            pad_in    = 8'($urandom);
            check_pins();
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule